// File: doc/BRIEF.md
# Corrected Single-Bit Error Threshold Counter

This block tallies corrected single-bit memory errors and raises an error report each time a programmable number of them has been seen. The error-correcting decoder upstream sends a one-cycle pulse for every single-bit error it corrects. The block keeps an 8-bit running count and an 8-bit threshold. Both sit in one 32-bit software register, and the upper half of that register always reads as zero.

When an increment makes the count equal to a nonzero threshold, the count returns to zero in the same step. If reporting is enabled at that moment, a sticky status bit sets and an interrupt request follows it. Because the count clears at every hit, a report arrives once every N corrected errors rather than the count saturating. Software clears the status with a write-one-to-clear strobe. It may also reload the count and the threshold at any time, and a register write takes priority over an error pulse in the same cycle.

Top module: `sbe_thresh_ctr`

## Requirements
- R1: Each cycle with `err_pulse_i` high and `reg_wr_i` low increases the count by one, and the new count is visible on the next clock edge.
- R2: The count reads back in `reg_rdata_o[7:0]` and the threshold in `reg_rdata_o[15:8]`. A write with `reg_wr_i` high loads both fields from the same bit positions of `reg_wdata_i`.
- R3: When an increment makes the count equal to a nonzero threshold while `report_en_i` is high, `status_o` is high from the next clock edge.
- R4: When an increment makes the count equal to a nonzero threshold, the count reads zero after that edge, whether or not reporting is enabled.
- R5: Bits [31:16] of `reg_rdata_o` always read zero, whatever value was written to them.
- R6: `status_o` stays high until a cycle with `status_clr_i` high clears it. If a new report and a clear fall in the same cycle, the report wins. `irq_o` equals `status_o` in every cycle.
- R7: A threshold hit while `report_en_i` is low clears the count but leaves `status_o` and `irq_o` unchanged.
- R8: In a cycle with both `reg_wr_i` and `err_pulse_i` high, the written count and threshold are taken as they are, and no threshold compare or report happens in that cycle.
- R9: With a threshold of zero no report is ever raised, and the count wraps from 255 to 0.
- R10: Reset clears the count, the threshold and the status bit, so all outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_pulse_i | input | 1 | One-cycle pulse for each corrected single-bit error |
| report_en_i | input | 1 | Enables raising a report at the threshold |
| reg_wr_i | input | 1 | Write strobe for the count/threshold register |
| reg_wdata_i | input | 32 | Write data: count in [7:0], threshold in [15:8] |
| status_clr_i | input | 1 | Write-one-to-clear strobe for the status bit |
| reg_rdata_o | output | 32 | Register read value |
| status_o | output | 1 | Sticky error-report status |
| irq_o | output | 1 | Machine-check/critical interrupt request |

## Verification
Every result of this block is due one clock edge after the stimulus that causes it. A pulse, a write or a clear presented in cycle k changes the count, threshold or status seen right after edge k+1. The interrupt follows the status bit in that same cycle, with no further delay. The bench drives each input on a falling edge, holds it across exactly one rising edge, and samples at the following falling edge, so each check sees the first cycle in which the result may appear. The same-cycle collisions (write with pulse, report with clear) are driven in a single cycle so that their priority shows up in that one sample.

// File: rtl/sbe_pkg.sv
package sbe_pkg;

    // Event the count core resolves for the current cycle.
    typedef enum logic [1:0] {
        EV_IDLE  = 2'd0,
        EV_LOAD  = 2'd1,
        EV_STEP  = 2'd2,
        EV_MATCH = 2'd3
    } ctr_event_e;

    // Register state of the report stage.
    typedef struct packed {
        logic flag;
    } report_state_t;

    // True when an event means the threshold was just reached.
    function automatic logic is_match(input ctr_event_e ev);
        return ev == EV_MATCH;
    endfunction

endpackage

// File: rtl/sbe_regmap.sv
module sbe_regmap #(
    parameter int REG_W   = 32,
    parameter int FIELD_W = 8,
    parameter int CNT_LSB = 0,
    parameter int THR_LSB = 8
) (
    input  logic [REG_W-1:0]   wdata_i,
    input  logic [FIELD_W-1:0] cnt_i,
    input  logic [FIELD_W-1:0] thr_i,
    output logic [FIELD_W-1:0] wr_cnt_o,
    output logic [FIELD_W-1:0] wr_thr_o,
    output logic [REG_W-1:0]   rdata_o
);

    localparam int CNT_MSB = CNT_LSB + FIELD_W - 1;
    localparam int THR_MSB = THR_LSB + FIELD_W - 1;

    // Extract write fields.
    assign wr_cnt_o = wdata_i[CNT_MSB:CNT_LSB];
    assign wr_thr_o = wdata_i[THR_MSB:THR_LSB];

    // Assemble read data bit by bit; every bit outside the two fields is zero.
    for (genvar b = 0; b < REG_W; b++) begin : g_rbit
        if (b >= CNT_LSB && b <= CNT_MSB) begin : g_cnt
            assign rdata_o[b] = cnt_i[b-CNT_LSB];
        end else if (b >= THR_LSB && b <= THR_MSB) begin : g_thr
            assign rdata_o[b] = thr_i[b-THR_LSB];
        end else begin : g_rsvd
            assign rdata_o[b] = 1'b0;
        end
    end

endmodule

// File: rtl/sbe_count_core.sv
module sbe_count_core
    import sbe_pkg::*;
#(
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               err_i,
    input  logic               wr_i,
    input  logic [FIELD_W-1:0] wr_cnt_i,
    input  logic [FIELD_W-1:0] wr_thr_i,
    output logic [FIELD_W-1:0] cnt_o,
    output logic [FIELD_W-1:0] thr_o,
    output ctr_event_e         event_o
);

    localparam logic [FIELD_W-1:0] ONE  = FIELD_W'(1);
    localparam logic [FIELD_W-1:0] ZERO = '0;

    typedef struct packed {
        logic [FIELD_W-1:0] cnt;
        logic [FIELD_W-1:0] thr;
    } core_state_t;

    core_state_t s_d, s_q;
    ctr_event_e  ev;
    logic [FIELD_W-1:0] inc;
    logic               thr_live;

    always_comb begin
        s_d      = s_q;
        inc      = s_q.cnt + ONE;
        thr_live = (s_q.thr != ZERO);
        ev       = EV_IDLE;
        if (wr_i) begin
            // Software write wins over a coincident pulse.
            ev      = EV_LOAD;
            s_d.cnt = wr_cnt_i;
            s_d.thr = wr_thr_i;
        end else if (err_i) begin
            if (thr_live && inc == s_q.thr) begin
                ev      = EV_MATCH;
                s_d.cnt = ZERO;
            end else begin
                ev      = EV_STEP;
                s_d.cnt = inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o   = s_q.cnt;
    assign thr_o   = s_q.thr;
    assign event_o = ev;

endmodule

// File: rtl/sbe_report.sv
module sbe_report
    import sbe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  ctr_event_e event_i,
    input  logic       en_i,
    input  logic       clr_i,
    output logic       status_o,
    output logic       irq_o
);

    report_state_t r_d, r_q;
    logic          raise;

    always_comb begin
        r_d   = r_q;
        raise = is_match(event_i) && en_i;
        if (raise) begin
            // A new report has priority over a coincident clear.
            r_d.flag = 1'b1;
        end else if (clr_i) begin
            r_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign status_o = r_q.flag;
    assign irq_o    = r_q.flag;

endmodule

// File: rtl/sbe_thresh_ctr.sv
module sbe_thresh_ctr
    import sbe_pkg::*;
#(
    parameter int REG_W   = 32,
    parameter int FIELD_W = 8,
    parameter int CNT_LSB = 0,
    parameter int THR_LSB = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_pulse_i,
    input  logic             report_en_i,
    input  logic             reg_wr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    input  logic             status_clr_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic             status_o,
    output logic             irq_o
);

    logic [FIELD_W-1:0] wr_cnt, wr_thr, cnt, thr;
    ctr_event_e         ev;

    sbe_regmap #(
        .REG_W  (REG_W),
        .FIELD_W(FIELD_W),
        .CNT_LSB(CNT_LSB),
        .THR_LSB(THR_LSB)
    ) u_map (
        .wdata_i (reg_wdata_i),
        .cnt_i   (cnt),
        .thr_i   (thr),
        .wr_cnt_o(wr_cnt),
        .wr_thr_o(wr_thr),
        .rdata_o (reg_rdata_o)
    );

    sbe_count_core #(
        .FIELD_W(FIELD_W)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_i   (err_pulse_i),
        .wr_i    (reg_wr_i),
        .wr_cnt_i(wr_cnt),
        .wr_thr_i(wr_thr),
        .cnt_o   (cnt),
        .thr_o   (thr),
        .event_o (ev)
    );

    sbe_report u_rep (
        .clk     (clk),
        .rst_n   (rst_n),
        .event_i (ev),
        .en_i    (report_en_i),
        .clr_i   (status_clr_i),
        .status_o(status_o),
        .irq_o   (irq_o)
    );

endmodule

// File: rtl/sbe_thresh_ctr_chk.sv
module sbe_thresh_ctr_chk #(
    parameter int REG_W   = 32,
    parameter int FIELD_W = 8,
    parameter int CNT_LSB = 0,
    parameter int THR_LSB = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             err_pulse_i,
    input logic             report_en_i,
    input logic             reg_wr_i,
    input logic [REG_W-1:0] reg_wdata_i,
    input logic             status_clr_i,
    input logic [REG_W-1:0] reg_rdata_o,
    input logic             status_o,
    input logic             irq_o
);

    localparam logic [REG_W-1:0] FIELD_MASK =
        ({{(REG_W-FIELD_W){1'b0}}, {FIELD_W{1'b1}}} << CNT_LSB) |
        ({{(REG_W-FIELD_W){1'b0}}, {FIELD_W{1'b1}}} << THR_LSB);

    logic [FIELD_W-1:0] c_cnt, c_thr, c_next, w_cnt, w_thr;
    logic               c_hit, c_step_zero;

    assign c_cnt       = reg_rdata_o[CNT_LSB +: FIELD_W];
    assign c_thr       = reg_rdata_o[THR_LSB +: FIELD_W];
    assign w_cnt       = reg_wdata_i[CNT_LSB +: FIELD_W];
    assign w_thr       = reg_wdata_i[THR_LSB +: FIELD_W];
    assign c_next      = c_cnt + FIELD_W'(1);
    assign c_hit       = err_pulse_i && !reg_wr_i && (c_thr != '0) && (c_next == c_thr);
    assign c_step_zero = err_pulse_i && !reg_wr_i && (c_thr == '0);

    p_report_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_hit && report_en_i) |=> status_o);

    p_clear_at_thr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        c_hit |=> (c_cnt == '0));

    p_reserved_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata_o & ~FIELD_MASK) == '0);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o && !status_clr_i) |=> status_o);

    p_irq_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == status_o);

    p_no_report_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!report_en_i && !status_o) |=> !status_o);

    p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_i |=> (c_cnt == $past(w_cnt) && c_thr == $past(w_thr)));

    p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        c_step_zero |=> (c_cnt == FIELD_W'($past(c_cnt) + 1'b1)));

endmodule

bind sbe_thresh_ctr sbe_thresh_ctr_chk #(
    .REG_W  (REG_W),
    .FIELD_W(FIELD_W),
    .CNT_LSB(CNT_LSB),
    .THR_LSB(THR_LSB)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_pulse_i (err_pulse_i),
    .report_en_i (report_en_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .status_clr_i(status_clr_i),
    .reg_rdata_o (reg_rdata_o),
    .status_o    (status_o),
    .irq_o       (irq_o)
);

// File: tb/sbe_thresh_ctr_tb_top.sv
`timescale 1ns/1ps
module sbe_thresh_ctr_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        err_pulse_i = 1'b0;
    logic        report_en_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic        status_clr_i = 1'b0;
    logic [31:0] reg_rdata_o;
    logic        status_o;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sbe_thresh_ctr dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .err_pulse_i (err_pulse_i),
        .report_en_i (report_en_i),
        .reg_wr_i    (reg_wr_i),
        .reg_wdata_i (reg_wdata_i),
        .status_clr_i(status_clr_i),
        .reg_rdata_o (reg_rdata_o),
        .status_o    (status_o),
        .irq_o       (irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // One cycle of stimulus: inputs set at a falling edge, cleared at the next.
    task automatic cycle(input logic err, input logic wr, input logic [31:0] wd, input logic clr);
        @(negedge clk);
        err_pulse_i  = err;
        reg_wr_i     = wr;
        reg_wdata_i  = wd;
        status_clr_i = clr;
        @(negedge clk);
        err_pulse_i  = 1'b0;
        reg_wr_i     = 1'b0;
        reg_wdata_i  = '0;
        status_clr_i = 1'b0;
    endtask

    task automatic load(input logic [7:0] thr, input logic [7:0] cnt);
        cycle(1'b0, 1'b1, {16'h0, thr, cnt}, 1'b0);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) cycle(1'b1, 1'b0, '0, 1'b0);
    endtask

    task automatic t_reset();
        check("R10 rdata", reg_rdata_o, 32'h0);
        check("R10 status", {31'h0, status_o}, 32'h0);
        check("R10 irq", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_count();
        report_en_i = 1'b1;
        load(8'd200, 8'd0);
        check("R2 threshold field", {24'h0, reg_rdata_o[15:8]}, 32'd200);
        pulses(1);
        check("R1 one step", {24'h0, reg_rdata_o[7:0]}, 32'd1);
        pulses(4);
        check("R1 five steps", {24'h0, reg_rdata_o[7:0]}, 32'd5);
        check("R1 no report below threshold", {31'h0, status_o}, 32'h0);
    endtask

    task automatic t_threshold();
        report_en_i = 1'b1;
        load(8'd3, 8'd0);
        pulses(2);
        check("R3 no report at two", {31'h0, status_o}, 32'h0);
        pulses(1);
        check("R4 count cleared at hit", {24'h0, reg_rdata_o[7:0]}, 32'd0);
        check("R3 status set at hit", {31'h0, status_o}, 32'h1);
        check("R6 irq with status", {31'h0, irq_o}, 32'h1);
    endtask

    task automatic t_sticky();
        pulses(1);
        check("R6 status sticky", {31'h0, status_o}, 32'h1);
        cycle(1'b0, 1'b0, '0, 1'b1);
        check("R6 status cleared", {31'h0, status_o}, 32'h0);
        check("R6 irq cleared", {31'h0, irq_o}, 32'h0);
        // count is 1 with threshold 3; load 2 and collide hit with clear
        load(8'd3, 8'd2);
        cycle(1'b1, 1'b0, '0, 1'b1);
        check("R6 report beats clear", {31'h0, status_o}, 32'h1);
        cycle(1'b0, 1'b0, '0, 1'b1);
    endtask

    task automatic t_disabled();
        report_en_i = 1'b0;
        load(8'd2, 8'd0);
        pulses(2);
        check("R7 count cleared without report", {24'h0, reg_rdata_o[7:0]}, 32'd0);
        check("R7 status stays low", {31'h0, status_o}, 32'h0);
        check("R7 irq stays low", {31'h0, irq_o}, 32'h0);
        report_en_i = 1'b1;
    endtask

    task automatic t_write_wins();
        load(8'd9, 8'd5);
        cycle(1'b1, 1'b1, 32'h0000_2010, 1'b0);
        check("R8 written value wins", {16'h0, reg_rdata_o[15:0]}, 32'h2010);
        // count 3, threshold 4: pulse would hit, write lands instead
        load(8'd4, 8'd3);
        cycle(1'b1, 1'b1, 32'h0000_0404, 1'b0);
        check("R8 no compare on write", {31'h0, status_o}, 32'h0);
        check("R8 count from write", {16'h0, reg_rdata_o[15:0]}, 32'h0404);
    endtask

    task automatic t_wrap();
        load(8'd0, 8'd254);
        pulses(1);
        check("R9 reaches 255", {24'h0, reg_rdata_o[7:0]}, 32'd255);
        pulses(1);
        check("R9 wraps to 0", {24'h0, reg_rdata_o[7:0]}, 32'd0);
        check("R9 no report", {31'h0, status_o}, 32'h0);
    endtask

    task automatic t_reserved();
        cycle(1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0);
        check("R5 reserved bits zero", reg_rdata_o, 32'h0000_FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_count();
        t_threshold();
        t_sticky();
        t_disabled();
        t_write_wins();
        t_wrap();
        t_reserved();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule